// File: doc/BRIEF.md
# Software-Acknowledge Resource Tracker

This block manages a small pool of destination-side acknowledge resources. Each incoming message that needs software to acknowledge it before the sender gets an answer takes one resource. The tracker finds a free resource and marks it pending. It then watches a programmable per-resource timer and raises reply strobes toward the network. Software acknowledges a message by writing a clear mask through a write-one-to-clear alias. It reads back a single status word that holds the pending and timeout bits of every resource.

If a message times out, the tracker sends an error reply at once but keeps the resource held until software clears the timeout bit. A message never gets more than one reply. When every resource is held, arrivals are stalled by dropping `msgReady`.

Top module: `ack_tracker`

## Requirements
- R1: The status word carries the pending bit of resource r at bit r+8 and its timeout bit at bit r. After reset all bits are 0 and all resources are free.
- R2: An arrival (`msgValid` and `msgReady` both high at a clock edge) takes the lowest-numbered free resource. That index is shown one-hot on `msgGrant` in the same cycle, and its pending bit is set after the edge.
- R3: A resource is free when both of its bits are 0. With no free resource, `msgReady` is low, `msgGrant` is zero and an offered message changes nothing.
- R4: Clearing the pending bit of a resource whose timeout bit is 0 frees it. In the cycle after the write, bit r of `replyOk` is high for exactly one cycle.
- R5: Suppose the limit L is nonzero and a resource stays pending without a clear. L edges after allocation its timeout bit becomes 1, and in that same cycle bit r of `replyErr` is high for one cycle. The pending bit stays 1 and the resource stays held.
- R6: Clearing the timeout bit of a timed-out resource clears both of its bits and frees it, with no reply. Clearing only its pending bit sends no reply, and the resource stays held.
- R7: Each allocation yields at most one reply. If a pending clear and the timer expiry of the same resource fall on the same edge, only the ok reply is sent and no timeout is recorded.
- R8: A clear write acts only on bits that are 1 in the written word and already set in the status word. Zero bits, and bits of free resources, have no effect. Writing a timeout bit that is not set leaves the pending bit unchanged.
- R9: A limit of 0 disables timeouts. Each resource's timer restarts at allocation and counts every cycle the resource is pending without timeout, whatever the limit is at the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmoLimit | input | TMO_W | Timeout limit in cycles, 0 disables |
| msgValid | input | 1 | A message is offered |
| msgReady | output | 1 | A free resource exists |
| msgGrant | output | 8 | One-hot index of the resource the offered message takes |
| clrWrite | input | 1 | Write strobe of the clear alias |
| clrData | input | 16 | Clear mask, same layout as the status word |
| statusWord | output | 16 | Pending bits [15:8], timeout bits [7:0] |
| replyOk | output | 8 | One-cycle pulse per resource, normal reply |
| replyErr | output | 8 | One-cycle pulse per resource, error reply |

## Verification
Allocation is driven three ways: in bursts until the pool is full, with a message held offered while full, and interleaved with clears. Together these show the lowest-free choice, the stall, and the reuse of a freed slot. Timeouts are tried with the limit at zero, at small values, and with a clear issued at each of a range of delays after allocation. One of those delays lands on the expiry edge, which separates the ok-wins rule from the early-error path. Clear masks with stray and zero bits, and a random mixed phase, check that only set bits of held resources react.

// File: rtl/ack_pkg.sv
package ack_pkg;
  localparam int ACK_NUM_RES = 8;

  typedef struct packed {
    logic [ACK_NUM_RES-1:0] alloc;    // resource taken this edge
    logic [ACK_NUM_RES-1:0] clrPend;  // pending bit cleared
    logic [ACK_NUM_RES-1:0] clrTmo;   // timeout bit cleared, resource freed
    logic [ACK_NUM_RES-1:0] setTmo;   // timer expiry accepted, error reply
    logic [ACK_NUM_RES-1:0] okReply;  // normal reply
  } ackStrobes_t;
endpackage

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import ack_pkg::*;
(
  input  logic [ACK_NUM_RES-1:0]   pendQ,
  input  logic [ACK_NUM_RES-1:0]   tmoQ,
  input  logic [ACK_NUM_RES-1:0]   expiring,
  input  logic                     msgValid,
  input  logic                     clrWrite,
  input  logic [2*ACK_NUM_RES-1:0] clrData,
  output logic                     msgReady,
  output logic [ACK_NUM_RES-1:0]   msgGrant,
  output ackStrobes_t              strb
);
  localparam int N = ACK_NUM_RES;

  logic [N-1:0] freeV, wrPend, wrTmo;

  always_comb begin
    freeV    = ~pendQ & ~tmoQ;
    msgGrant = freeV & (~freeV + 1'b1);   // lowest set bit
    msgReady = |freeV;
    wrPend   = clrWrite ? clrData[2*N-1:N] : '0;
    wrTmo    = clrWrite ? clrData[N-1:0]   : '0;

    strb.alloc   = msgValid ? msgGrant : '0;
    strb.clrPend = wrPend & pendQ;
    strb.clrTmo  = wrTmo & tmoQ;
    strb.okReply = wrPend & pendQ & ~tmoQ;
    strb.setTmo  = expiring & ~strb.okReply;
  end
endmodule

// File: rtl/ack_datapath.sv
module ack_datapath
  import ack_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ackStrobes_t            strb,
  input  logic [TMO_W-1:0]       tmoLimit,
  output logic [ACK_NUM_RES-1:0] pendQ,
  output logic [ACK_NUM_RES-1:0] tmoQ,
  output logic [ACK_NUM_RES-1:0] expiring,
  output logic [ACK_NUM_RES-1:0] replyOk,
  output logic [ACK_NUM_RES-1:0] replyErr
);
  localparam int N = ACK_NUM_RES;
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      tmoQ     <= '0;
      replyOk  <= '0;
      replyErr <= '0;
    end else begin
      pendQ    <= (pendQ & ~strb.clrPend & ~strb.clrTmo) | strb.alloc;
      tmoQ     <= (tmoQ & ~strb.clrTmo) | strb.setTmo;
      replyOk  <= strb.okReply;
      replyErr <= strb.setTmo;
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_timer
    logic [TMO_W-1:0] cnt;
    logic             running;

    assign running = pendQ[r] & ~tmoQ[r];

    always_ff @(posedge clk) begin
      if (!rstN)                          cnt <= '0;
      else if (strb.alloc[r])             cnt <= '0;
      else if (running && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign expiring[r] = running && (tmoLimit != '0) &&
                         ({1'b0, cnt} + 1'b1 >= {1'b0, tmoLimit});
  end
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker
  import ack_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [TMO_W-1:0]         tmoLimit,
  input  logic                     msgValid,
  output logic                     msgReady,
  output logic [ACK_NUM_RES-1:0]   msgGrant,
  input  logic                     clrWrite,
  input  logic [2*ACK_NUM_RES-1:0] clrData,
  output logic [2*ACK_NUM_RES-1:0] statusWord,
  output logic [ACK_NUM_RES-1:0]   replyOk,
  output logic [ACK_NUM_RES-1:0]   replyErr
);
  ackStrobes_t            strb;
  logic [ACK_NUM_RES-1:0] pendQ, tmoQ, expiring;

  ack_ctrl u_ctrl (
    .pendQ(pendQ), .tmoQ(tmoQ), .expiring(expiring),
    .msgValid(msgValid), .clrWrite(clrWrite), .clrData(clrData),
    .msgReady(msgReady), .msgGrant(msgGrant), .strb(strb)
  );

  ack_datapath #(.TMO_W(TMO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tmoLimit(tmoLimit),
    .pendQ(pendQ), .tmoQ(tmoQ), .expiring(expiring),
    .replyOk(replyOk), .replyErr(replyErr)
  );

  assign statusWord = {pendQ, tmoQ};
endmodule

// File: rtl/ack_tracker_chk.sv
module ack_tracker_chk
  import ack_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     msgReady,
  input logic [ACK_NUM_RES-1:0]   msgGrant,
  input logic                     clrWrite,
  input logic [2*ACK_NUM_RES-1:0] clrData,
  input logic [2*ACK_NUM_RES-1:0] statusWord,
  input logic [ACK_NUM_RES-1:0]   replyOk,
  input logic [ACK_NUM_RES-1:0]   replyErr
);
  localparam int N = ACK_NUM_RES;

  logic [N-1:0] sPend, sTmo, wrTmoMask;
  assign sPend     = statusWord[2*N-1:N];
  assign sTmo      = statusWord[N-1:0];
  assign wrTmoMask = clrWrite ? clrData[N-1:0] : '0;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(msgGrant));

  // R2
  grant_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgGrant & (sPend | sTmo)) == '0);

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !msgReady |-> ((sPend | sTmo) == '1 && msgGrant == '0));

  // R7
  single_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replyOk & replyErr) == '0);

  // R4
  ok_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((replyOk & ~$past(sPend & ~sTmo)) == '0));

  // R5
  err_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replyErr & ~(sTmo & sPend)) == '0);

  // R6
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~sTmo & $past(sTmo) & ~$past(wrTmoMask)) == '0));
endmodule

bind ack_tracker ack_tracker_chk u_chk (
  .clk(clk), .rstN(rstN), .msgReady(msgReady), .msgGrant(msgGrant),
  .clrWrite(clrWrite), .clrData(clrData), .statusWord(statusWord),
  .replyOk(replyOk), .replyErr(replyErr)
);

// File: tb/ack_tracker_tb.sv
module ack_tracker_tb;
  localparam int NR = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tmoLimit = '0;
  logic          msgValid = 1'b0;
  logic          clrWrite = 1'b0;
  logic [2*NR-1:0] clrData = '0;
  logic          msgReady;
  logic [NR-1:0] msgGrant, replyOk, replyErr;
  logic [2*NR-1:0] statusWord;

  int checks = 0;
  int fails = 0;
  string curTag = "R1";

  always #5 clk = ~clk;

  ack_tracker #(.TMO_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .tmoLimit(tmoLimit), .msgValid(msgValid),
    .msgReady(msgReady), .msgGrant(msgGrant), .clrWrite(clrWrite),
    .clrData(clrData), .statusWord(statusWord), .replyOk(replyOk),
    .replyErr(replyErr)
  );

  // reference model
  logic [NR-1:0] mPend, mTmo, mOk, mErr;
  int mCnt [NR];

  function automatic logic [NR-1:0] freeVec();
    return ~mPend & ~mTmo;
  endfunction

  function automatic logic [NR-1:0] lowestFree();
    logic [NR-1:0] f = freeVec();
    for (int i = 0; i < NR; i++) if (f[i]) return NR'(1) << i;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mTmo = '0; mOk = '0; mErr = '0;
      for (int i = 0; i < NR; i++) mCnt[i] = 0;
    end else begin
      logic [NR-1:0] g, wP, wT, ok, ex, nP, nT;
      g  = msgValid ? lowestFree() : '0;
      wP = clrWrite ? clrData[2*NR-1:NR] : '0;
      wT = clrWrite ? clrData[NR-1:0] : '0;
      ok = wP & mPend & ~mTmo;
      ex = '0;
      for (int i = 0; i < NR; i++)
        if (mPend[i] && !mTmo[i] && tmoLimit != 0 && !ok[i] &&
            mCnt[i] + 1 >= int'(tmoLimit)) ex[i] = 1'b1;
      nP = (mPend & ~wP & ~(wT & mTmo)) | g;
      nT = (mTmo & ~wT) | ex;
      for (int i = 0; i < NR; i++) begin
        if (g[i]) mCnt[i] = 0;
        else if (mPend[i] && !mTmo[i] && mCnt[i] < 65535) mCnt[i]++;
      end
      mPend = nP; mTmo = nT; mOk = ok; mErr = ex;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check({curTag, " R1 status"}, 32'(statusWord), 32'({mPend, mTmo}));
      check({curTag, " R2 grant"},  32'(msgGrant),   32'(lowestFree()));
      check({curTag, " R3 ready"},  32'(msgReady),   32'(|freeVec()));
      check({curTag, " R4 ok"},     32'(replyOk),    32'(mOk));
      check({curTag, " R5 err"},    32'(replyErr),   32'(mErr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendMsg();
    @(negedge clk); msgValid = 1'b1;
    @(negedge clk); msgValid = 1'b0;
  endtask

  task automatic clearW(logic [2*NR-1:0] d);
    @(negedge clk); clrWrite = 1'b1; clrData = d;
    @(negedge clk); clrWrite = 1'b0; clrData = '0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset status", 32'(statusWord), 32'h0);
    check("R1 reset ready", 32'(msgReady), 32'h1);

    // R2 / R9: burst with timeouts disabled
    curTag = "R9";
    tmoLimit = 0;
    @(negedge clk); msgValid = 1'b1;
    idle(3);
    msgValid = 1'b0;
    idle(30);
    check("R9 no timeout with limit 0", 32'(statusWord[NR-1:0]), 32'h0);

    // R4: clear pending of resource 1, then R2 reuse
    curTag = "R4";
    clearW(16'h0200);
    check("R4 freed", 32'(statusWord), 32'h0500);
    curTag = "R2";
    sendMsg();
    check("R2 lowest reused", 32'(statusWord), 32'h0700);

    // R3: fill and hold while full
    curTag = "R3";
    @(negedge clk); msgValid = 1'b1;
    idle(10);
    msgValid = 1'b0;
    check("R3 full", 32'(statusWord), 32'hFF00);

    // R5: enable timeout, all long-pending resources expire
    curTag = "R5";
    tmoLimit = 4;
    idle(3);
    check("R5 all timed out", 32'(statusWord), 32'hFFFF);

    // R6: pending-only clear keeps resource; timeout clear frees it
    curTag = "R6";
    clearW(16'h0100);
    check("R6 pend-only clear held", 32'(statusWord), 32'hFEFF);
    clearW(16'h0001);
    check("R6 tmo clear frees", 32'(statusWord), 32'hFEFE);
    clearW(16'h0002);
    check("R6 tmo clear frees pending too", 32'(statusWord), 32'hFCFC);

    // R8: stray bits on free resources and zero words
    curTag = "R8";
    clearW(16'h0000);
    clearW(16'h0300);
    check("R8 stray bits ignored", 32'(statusWord), 32'hFCFC);
    clearW(16'hFCFC);
    check("R8 all cleared", 32'(statusWord), 32'h0000);

    // R8: timeout bit written on a non-timed-out resource
    tmoLimit = 0;
    sendMsg();
    clearW(16'h0001);
    check("R8 tmo write leaves pending", 32'(statusWord), 32'h0100);
    clearW(16'h0100);

    // R7: clear at each delay around the expiry edge
    curTag = "R7";
    tmoLimit = 4;
    for (int d = 0; d < 8; d++) begin
      sendMsg();
      idle(d);
      clearW(16'h0101);
      idle(2);
    end

    // R9: timer restarts on each allocation
    curTag = "R9";
    tmoLimit = 6;
    sendMsg();
    idle(2);
    clearW(16'h0100);
    sendMsg();
    idle(3);
    check("R9 restart no early expiry", 32'(statusWord), 32'h0100);
    idle(4);
    check("R9 expiry after restart", 32'(statusWord), 32'h0101);
    clearW(16'h0001);

    // mixed random phase
    curTag = "R8";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      msgValid = ($urandom_range(0, 2) == 0);
      clrWrite = ($urandom_range(0, 2) == 0);
      clrData  = 16'($urandom);
      if (k % 100 == 0) tmoLimit = 16'($urandom_range(0, 12));
    end
    @(negedge clk);
    msgValid = 1'b0; clrWrite = 1'b0; clrData = '0;
    idle(4);
    finishRun();
  end
endmodule